// File: doc/BRIEF.md
# Flag Offset Register Loader

This block sets the two threshold offsets that a 2,048-word FIFO uses for its programmable flags: an almost-empty offset (X) and an almost-full offset (Y), each 11 bits wide. A 3-bit method select is sampled while reset is held. It picks one of three ways to fill the offsets. The first places a fixed preset value in both registers. The second takes the two offsets from the write data bus over two write strobes. The third shifts the offsets in one bit at a time on the write clock.

The `prog_done` output goes high once both offsets hold their final values. The surrounding FIFO may only evaluate its flags after that point. After `prog_done` rises, every loading strobe is ignored until the next reset, so the write bus and the serial pins can go back to ordinary use. Flag comparison is not part of this block.

The reset is synchronous and active low. The method select is taken on every clock edge at which reset is low, and the value present at the last such edge is the one that counts.

Top module: `flo_offset_loader`

## Requirements
- R1: While `rst_n` is low, `prog_done` is 0 one edge later. The method is taken from `meth_sel` only on edges where reset is low, so changing `meth_sel` after reset has no effect on the method or the offsets.
- R2: `meth_sel` codes 3'b001, 3'b010, 3'b011, 3'b100 and 3'b101 load 8, 16, 64, 256 and 1,024 into both `x_off` and `y_off`. `prog_done` is 1 after the first clock edge with `rst_n` high.
- R3: `meth_sel` code 3'b000 acts as a preset code and loads 64 into both offsets.
- R4: Code 3'b110 selects parallel loading. The first edge with `wr_en` high loads `x_off` from `wr_data[10:0]`. The second such edge loads `y_off` from `wr_data[10:0]` and sets `prog_done`.
- R5: In parallel loading, `wr_data` bits above bit 10 do not reach the offsets. Write strobes after `prog_done` leave both offsets unchanged.
- R6: Code 3'b111 selects serial loading. Each clock edge with `ser_en_n` low shifts `ser_bit` into a 22-bit chain. The first bit shifted ends up as the MSB of `y_off`, and the last bit as the LSB of `x_off`.
- R7: In serial loading, `prog_done` rises at the edge that takes the 22nd bit and not before. Edges with `ser_en_n` high are not counted.
- R8: Serial strobes after `prog_done` leave both offsets unchanged. Once `prog_done` is high it stays high until reset.
- R9: The parallel and serial methods start with both offsets at 0. Each ignores the strobes of the other method.
- R10: A new reset clears `prog_done` and restarts programming with the method sampled during that reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-side clock |
| rst_n | input | 1 | Synchronous active-low reset; method is sampled while low |
| meth_sel | input | 3 | Programming method select |
| wr_en | input | 1 | Write strobe, used for parallel loading |
| wr_data | input | 36 | Write data bus; offsets taken from bits 10:0 |
| ser_en_n | input | 1 | Active-low serial shift enable |
| ser_bit | input | 1 | Serial data bit |
| x_off | output | 11 | Almost-empty offset |
| y_off | output | 11 | Almost-full offset |
| prog_done | output | 1 | Offsets are final; flags may be evaluated |

## Verification
The bench builds the block with its default parameters: 11-bit offsets and a 36-bit data bus. That makes the serial chain the full 22 bits, so a bench step can land exactly on the boundary between bit 21 and bit 22. It also lets the 1,024 preset use the top offset bit. The 36-bit bus leaves 25 upper data bits, which the bench fills with nonzero values to show that they never reach an offset.

// File: rtl/flo_pkg.sv
package flo_pkg;

  typedef enum logic [1:0] {
    MODE_PRESET   = 2'd0,
    MODE_PARALLEL = 2'd1,
    MODE_SERIAL   = 2'd2
  } flo_mode_e;

  // Method decode: the top two codes pick the loaders, every other code is a preset.
  function automatic flo_mode_e flo_mode_of(input logic [2:0] code);
    case (code)
      3'b110:  return MODE_PARALLEL;
      3'b111:  return MODE_SERIAL;
      default: return MODE_PRESET;
    endcase
  endfunction

  // Preset values; unlisted codes fall back to 64.
  function automatic int unsigned flo_preset_of(input logic [2:0] code);
    case (code)
      3'b001:  return 8;
      3'b010:  return 16;
      3'b011:  return 64;
      3'b100:  return 256;
      3'b101:  return 1024;
      default: return 64;
    endcase
  endfunction

endpackage

// File: rtl/flo_mode_latch.sv
module flo_mode_latch
  import flo_pkg::*;
#(
  parameter int OFF_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       meth_sel,
  output flo_mode_e        mode,
  output logic [OFF_W-1:0] preset_val
);

  // Capture on every edge with reset low; hold afterwards.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode       <= flo_mode_of(meth_sel);
      preset_val <= OFF_W'(flo_preset_of(meth_sel));
    end
  end

endmodule

// File: rtl/flo_par_loader.sv
module flo_par_loader #(
  parameter int OFF_W  = 11,
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [OFF_W-1:0]  x_val,
  output logic [OFF_W-1:0]  y_val,
  output logic              done,
  output logic              par_wr_x,
  output logic              par_wr_y
);

  logic             second;   // X already written
  logic [OFF_W-1:0] low_data;
  logic             unused_hi;

  assign low_data  = wr_data[OFF_W-1:0];
  assign unused_hi = ^wr_data[DATA_W-1:OFF_W];

  assign par_wr_x = active && wr_en && !done && !second;
  assign par_wr_y = active && wr_en && !done &&  second;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_val  <= '0;
      y_val  <= '0;
      second <= 1'b0;
      done   <= 1'b0;
    end else begin
      if (par_wr_x) begin
        x_val  <= low_data;
        second <= 1'b1;
      end
      if (par_wr_y) begin
        y_val <= low_data;
        done  <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/flo_ser_loader.sv
module flo_ser_loader #(
  parameter int OFF_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             ser_en_n,
  input  logic             ser_bit,
  output logic [OFF_W-1:0] x_val,
  output logic [OFF_W-1:0] y_val,
  output logic             done,
  output logic             ser_shift,
  output logic             ser_last
);

  localparam int CHAIN_W = 2 * OFF_W;
  localparam int CNT_W   = $clog2(CHAIN_W + 1);

  logic [CHAIN_W-1:0] chain;
  logic [CNT_W-1:0]   bit_cnt;

  assign ser_shift = active && !ser_en_n && !done;
  assign ser_last  = ser_shift && (bit_cnt == CNT_W'(CHAIN_W - 1));

  // Y occupies the upper half of the chain, so the first bit in ends as Y's MSB.
  assign y_val = chain[CHAIN_W-1:OFF_W];
  assign x_val = chain[OFF_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain   <= '0;
      bit_cnt <= '0;
      done    <= 1'b0;
    end else if (ser_shift) begin
      chain   <= {chain[CHAIN_W-2:0], ser_bit};
      bit_cnt <= bit_cnt + CNT_W'(1);
      if (ser_last) done <= 1'b1;
    end
  end

endmodule

// File: rtl/flo_offset_loader.sv
module flo_offset_loader
  import flo_pkg::*;
#(
  parameter int OFF_W  = 11,
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        meth_sel,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ser_en_n,
  input  logic              ser_bit,
  output logic [OFF_W-1:0]  x_off,
  output logic [OFF_W-1:0]  y_off,
  output logic              prog_done
);

  flo_mode_e        mode;
  logic [OFF_W-1:0] preset_val;
  logic             pre_done;
  logic [OFF_W-1:0] par_x, par_y, ser_x, ser_y;
  logic             par_done, ser_done;
  logic             par_wr_x, par_wr_y, ser_shift, ser_last;
  logic             par_act, ser_act;

  assign par_act = (mode == MODE_PARALLEL);
  assign ser_act = (mode == MODE_SERIAL);

  flo_mode_latch #(.OFF_W(OFF_W)) u_mode (
    .clk(clk), .rst_n(rst_n), .meth_sel(meth_sel),
    .mode(mode), .preset_val(preset_val)
  );

  flo_par_loader #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_par (
    .clk(clk), .rst_n(rst_n), .active(par_act),
    .wr_en(wr_en), .wr_data(wr_data),
    .x_val(par_x), .y_val(par_y), .done(par_done),
    .par_wr_x(par_wr_x), .par_wr_y(par_wr_y)
  );

  flo_ser_loader #(.OFF_W(OFF_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .active(ser_act),
    .ser_en_n(ser_en_n), .ser_bit(ser_bit),
    .x_val(ser_x), .y_val(ser_y), .done(ser_done),
    .ser_shift(ser_shift), .ser_last(ser_last)
  );

  // Presets are final one edge after reset releases.
  always_ff @(posedge clk) begin
    if (!rst_n) pre_done <= 1'b0;
    else        pre_done <= 1'b1;
  end

  always_comb begin
    case (mode)
      MODE_PARALLEL: begin x_off = par_x; y_off = par_y; prog_done = par_done; end
      MODE_SERIAL:   begin x_off = ser_x; y_off = ser_y; prog_done = ser_done; end
      default:       begin x_off = preset_val; y_off = preset_val; prog_done = pre_done; end
    endcase
  end

endmodule

// File: rtl/flo_chk.sv
module flo_chk
  import flo_pkg::*;
#(
  parameter int OFF_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input flo_mode_e        mode,
  input logic [OFF_W-1:0] low_data,
  input logic             ser_bit,
  input logic [OFF_W-1:0] x_off,
  input logic [OFF_W-1:0] y_off,
  input logic             prog_done,
  input logic             par_wr_x,
  input logic             par_wr_y,
  input logic             ser_shift,
  input logic             ser_last
);

  // R1
  reset_clears_done_chk: assert property (@(posedge clk) !rst_n |=> !prog_done);

  // R2
  preset_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_PRESET) |-> (x_off == y_off));

  // R4
  par_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_wr_x |=> (x_off == $past(low_data)) && !prog_done);

  // R4
  par_y_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_wr_y |=> (y_off == $past(low_data)) && prog_done);

  // R6
  ser_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_shift |=> (x_off[0] == $past(ser_bit))
               && (x_off[OFF_W-1:1] == $past(x_off[OFF_W-2:0]))
               && (y_off == {$past(y_off[OFF_W-2:0]), $past(x_off[OFF_W-1])}));

  // R7
  ser_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_last |=> prog_done);

  // R7
  ser_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_shift && !ser_last) |=> !prog_done);

  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |=> prog_done);

  // R8
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |=> $stable(x_off) && $stable(y_off));

endmodule

bind flo_offset_loader flo_chk #(.OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .low_data(wr_data[OFF_W-1:0]),
  .ser_bit(ser_bit), .x_off(x_off), .y_off(y_off), .prog_done(prog_done),
  .par_wr_x(par_wr_x), .par_wr_y(par_wr_y),
  .ser_shift(ser_shift), .ser_last(ser_last)
);

// File: tb/tb_flo_offset_loader.sv
`timescale 1ns/1ps
module tb_flo_offset_loader;

  localparam int OFF_W  = 11;
  localparam int DATA_W = 36;
  localparam int CHAIN  = 2 * OFF_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [2:0]        meth_sel = 3'b000;
  logic              wr_en = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              ser_en_n = 1'b1;
  logic              ser_bit = 1'b0;
  logic [OFF_W-1:0]  x_off, y_off;
  logic              prog_done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  flo_offset_loader #(.OFF_W(OFF_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst_n(rst_n), .meth_sel(meth_sel), .wr_en(wr_en),
    .wr_data(wr_data), .ser_en_n(ser_en_n), .ser_bit(ser_bit),
    .x_off(x_off), .y_off(y_off), .prog_done(prog_done)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !finished) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung (actual %0d cycles, expected < 20000)", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int unsigned preset_model(input logic [2:0] c);
    int unsigned v [6] = '{64, 8, 16, 64, 256, 1024};
    return (c <= 3'd5) ? v[c] : 0;
  endfunction

  // Hold reset for two edges, then release and move meth_sel away.
  task automatic do_reset(input logic [2:0] code);
    @(negedge clk);
    rst_n = 1'b0; meth_sel = code; wr_en = 1'b0; ser_en_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 done low in reset", prog_done, 0);
    chk("R10 done cleared by reset", prog_done, 0);
    rst_n = 1'b1;
    meth_sel = ~code;
  endtask

  task automatic t_presets();
    for (int c = 0; c < 6; c++) begin
      do_reset(3'(c));
      @(negedge clk);
      chk(c == 0 ? "R3 unused code x" : "R2 preset x", x_off, preset_model(3'(c)));
      chk(c == 0 ? "R3 unused code y" : "R2 preset y", y_off, preset_model(3'(c)));
      chk("R2 preset done", prog_done, 1);
      chk("R1 sel ignored after reset", x_off, preset_model(3'(c)));
    end
  endtask

  task automatic t_parallel();
    do_reset(3'b110);
    @(negedge clk);
    chk("R9 parallel start x", x_off, 0);
    chk("R9 parallel start done", prog_done, 0);
    ser_en_n = 1'b0; ser_bit = 1'b1;
    repeat (3) @(negedge clk);
    ser_en_n = 1'b1;
    chk("R9 serial strobe ignored x", x_off, 0);
    chk("R9 serial strobe ignored y", y_off, 0);
    wr_en = 1'b1; wr_data = {25'h1F0F0F0, 11'h5A3};
    @(negedge clk);
    chk("R4 x written", x_off, 11'h5A3);
    chk("R4 no done after first", prog_done, 0);
    wr_data = {25'h0ABCDEF, 11'h2C7};
    @(negedge clk);
    wr_en = 1'b0;
    chk("R4 y written", y_off, 11'h2C7);
    chk("R5 upper bits dropped", x_off, 11'h5A3);
    chk("R4 done after second", prog_done, 1);
    wr_en = 1'b1; wr_data = '1;
    repeat (2) @(negedge clk);
    wr_en = 1'b0;
    chk("R5 late write x", x_off, 11'h5A3);
    chk("R5 late write y", y_off, 11'h2C7);
  endtask

  task automatic shift_in(input logic [CHAIN-1:0] v, input bit gaps, input bit stop_early);
    for (int i = 0; i < CHAIN; i++) begin
      ser_en_n = 1'b0; ser_bit = v[CHAIN-1-i];
      @(negedge clk);
      if (gaps && (i % 5 == 2)) begin
        ser_en_n = 1'b1; ser_bit = ~ser_bit;
        repeat (2) @(negedge clk);
      end
      if (i == CHAIN - 2) chk("R7 no done after 21 bits", prog_done, 0);
      if (stop_early && i == CHAIN - 2) break;
    end
    ser_en_n = 1'b1;
  endtask

  task automatic t_serial();
    logic [CHAIN-1:0] v = 22'h2D5A3C;
    do_reset(3'b111);
    @(negedge clk);
    chk("R9 serial start y", y_off, 0);
    wr_en = 1'b1; wr_data = '1;
    repeat (2) @(negedge clk);
    wr_en = 1'b0;
    chk("R9 write strobe ignored x", x_off, 0);
    chk("R9 write strobe ignored done", prog_done, 0);
    shift_in(v, 1'b1, 1'b0);
    chk("R7 done at 22nd bit", prog_done, 1);
    chk("R6 y from first bits", y_off, v[CHAIN-1:OFF_W]);
    chk("R6 x from last bits", x_off, v[OFF_W-1:0]);
    ser_en_n = 1'b0; ser_bit = 1'b1;
    repeat (5) @(negedge clk);
    ser_en_n = 1'b1;
    chk("R8 extra bits y", y_off, v[CHAIN-1:OFF_W]);
    chk("R8 extra bits x", x_off, v[OFF_W-1:0]);
    chk("R8 done held", prog_done, 1);
  endtask

  task automatic t_rereset();
    logic [CHAIN-1:0] w = 22'h3FF801;
    do_reset(3'b111);
    @(negedge clk);
    chk("R10 offsets cleared", {21'd0, x_off}, 0);
    shift_in(w, 1'b0, 1'b1);
    chk("R7 still waiting", prog_done, 0);
    do_reset(3'b111);
    shift_in(w, 1'b0, 1'b0);
    chk("R10 restart y", y_off, w[CHAIN-1:OFF_W]);
    chk("R10 restart x", x_off, w[OFF_W-1:0]);
    do_reset(3'b100);
    @(negedge clk);
    chk("R10 new method preset", y_off, 256);
  endtask

  initial begin
    t_presets();
    t_parallel();
    t_serial();
    t_rereset();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule